// File: doc/BRIEF.md
# Trace Capture Sync Detector

This block sits at the receiving end of a narrow trace port. Each clock it samples one, two or four data pins and treats them as a serial bit stream, least significant bit first. It does not know where words begin until it finds the full-word alignment pattern, a 32-bit value of 0x7FFFFFFF (thirty-one ones followed by a single zero on the wire). It searches for this pattern at every bit offset. Once the pattern is found, the block counts the stream in 16-bit units and builds aligned 32-bit words from them. Alignment and idle fill are removed before anything reaches the output.

Control is a three-state machine. ST_HUNT searches for alignment and emits nothing. Its transition *lock* leads to ST_LO when the pattern is seen. ST_LO waits for the low half of a word. There, *take_low* (a data half) moves to ST_HI, and *idle_low* (the half 0x7FFF) stays in ST_LO. ST_HI holds a pending low half. Its transitions are: *emit* (a data half completes a word) back to ST_LO; *strip_sync* (pending 0xFFFF followed by 0x7FFF, a repeated full-word pattern) back to ST_LO with nothing sent; *idle_high* (0x7FFF after any other pending half) stays in ST_HI. Reset returns the machine to ST_HUNT from any state.

A downstream frame decoder consumes the word stream. It reads `synced` to know that alignment has been found and `idle` to know that the port is only sending fill.

Top module: `trace_sync_detect`

## Requirements
- R1: While reset is asserted and just after it, `synced`, `idle` and `word_valid` are all 0.
- R2: `width_sel` = 0 uses pin 0 only, 1 uses pins 1:0, and 2 or 3 uses pins 3:0. Within a cycle, pin 0 carries the earliest bit. Unused pins have no effect.
- R3: Before alignment, `word_valid` stays 0 whatever arrives on the pins, and the search considers every bit offset, including offsets that do not fall on a sampling-cycle boundary.
- R4: Alignment is recognised when the 32 most recent bits, in arrival order, are thirty-one ones and then a zero. `synced` then rises and stays high until reset. The bit after that zero starts the first 16-bit unit.
- R5: After alignment, two consecutive data halves form one output word, the first received half being bits 15:0. The word appears on `word_data` with a `word_valid` pulse of one cycle.
- R6: A full-word pattern (0x7FFFFFFF) arriving after alignment produces no output word.
- R7: Any 16-bit unit equal to 0x7FFF after alignment is dropped, including one that falls between the two halves of a word. In that case the halves on either side still join into one word.
- R8: `idle` goes to 1 when a 0x7FFF unit is dropped and returns to 0 in the cycle a word is emitted. Stripping a full-word pattern does not change it.
- R9: A pending low half of 0xFFFF followed by 0x7FFF is stripped as a full-word pattern. A pending 0xFFFF followed by any other half forms a normal word.
- R10: Asserting reset in mid-stream clears `synced` at once. Afterwards, no word is emitted until the alignment pattern is found again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| width_sel | input | 2 | Active pin count: 0 = one pin, 1 = two pins, 2 or 3 = four pins |
| pin_data | input | 4 | Trace data pins; pin 0 carries the earliest bit |
| word_data | output | 32 | Aligned data word, first-received half in bits 15:0 |
| word_valid | output | 1 | One-cycle pulse qualifying `word_data` |
| synced | output | 1 | Word alignment has been found |
| idle | output | 1 | The last event was dropped idle fill |

## Verification
The delicate case is a 16-bit unit that completes a word and could also be the tail of a full-word pattern. The choice between *emit* and *strip_sync* is made at a single half boundary. The bench provokes it by sending a low half of 0xFFFF followed first by 0x7FFF and then by 0x1234. The first pair must yield no word and leave `idle` unchanged. The second pair must yield 0x1234FFFF. A related collision is an idle half arriving while a low half is pending. Here the bench checks that exactly one word made from the surrounding halves appears and that `idle` drops in the same cycle as that word.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2
    } tsd_state_e;

    typedef enum logic [1:0] {
        WSEL_ONE  = 2'd0,
        WSEL_TWO  = 2'd1,
        WSEL_FOUR = 2'd2,
        WSEL_WIDE = 2'd3
    } tsd_width_e;

endpackage

// File: rtl/tsd_width_dec.sv
module tsd_width_dec #(
    parameter int MAX_PINS = 4,
    localparam int LANE_W  = $clog2(MAX_PINS + 1)
) (
    input  logic [1:0]        width_sel,
    output logic [LANE_W-1:0] lane_cnt
);
    import tsd_pkg::*;

    localparam logic [LANE_W-1:0] LANES_MAX = LANE_W'(MAX_PINS);

    always_comb begin
        unique case (tsd_width_e'(width_sel))
            WSEL_ONE:  lane_cnt = LANE_W'(1);
            WSEL_TWO:  lane_cnt = (MAX_PINS >= 2) ? LANE_W'(2) : LANES_MAX;
            WSEL_FOUR: lane_cnt = (MAX_PINS >= 4) ? LANE_W'(4) : LANES_MAX;
            default:   lane_cnt = (MAX_PINS >= 4) ? LANE_W'(4) : LANES_MAX;
        endcase
    end

endmodule

// File: rtl/tsd_bit_shift.sv
module tsd_bit_shift #(
    parameter int MAX_PINS = 4,
    parameter int WORD_W   = 32,
    localparam int HALF_W  = WORD_W / 2,
    localparam int LANE_W  = $clog2(MAX_PINS + 1),
    localparam int CNT_W   = $clog2(HALF_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANE_W-1:0]   lane_cnt,
    input  logic [MAX_PINS-1:0] pins,
    output logic                found,
    output logic                half_done,
    output logic [HALF_W-1:0]   half_val
);

    localparam logic [WORD_W-1:0] FULL_PAT = {1'b0, {(WORD_W-1){1'b1}}};

    logic [WORD_W-1:0] win_q, win_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              lock_q, lock_d;
    logic              fnd_d, hd_d;
    logic [HALF_W-1:0] hv_d;

    // Walk the bits of this cycle one at a time so every offset is tested.
    always_comb begin
        win_d  = win_q;
        cnt_d  = cnt_q;
        lock_d = lock_q;
        fnd_d  = 1'b0;
        hd_d   = 1'b0;
        hv_d   = half_val;
        for (int i = 0; i < MAX_PINS; i++) begin
            if (i < int'(lane_cnt)) begin
                win_d = {pins[i], win_d[WORD_W-1:1]};
                if (!lock_d) begin
                    if (win_d == FULL_PAT) begin
                        lock_d = 1'b1;
                        fnd_d  = 1'b1;
                        cnt_d  = '0;
                    end
                end else begin
                    cnt_d = cnt_d + 1'b1;
                    if (cnt_d == CNT_W'(HALF_W)) begin
                        cnt_d = '0;
                        hd_d  = 1'b1;
                        hv_d  = win_d[WORD_W-1:HALF_W];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q     <= '0;
            cnt_q     <= '0;
            lock_q    <= 1'b0;
            found     <= 1'b0;
            half_done <= 1'b0;
            half_val  <= '0;
        end else begin
            win_q     <= win_d;
            cnt_q     <= cnt_d;
            lock_q    <= lock_d;
            found     <= fnd_d;
            half_done <= hd_d;
            half_val  <= hv_d;
        end
    end

endmodule

// File: rtl/tsd_half_fsm.sv
module tsd_half_fsm #(
    parameter int WORD_W  = 32,
    localparam int HALF_W = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              found,
    input  logic              half_done,
    input  logic [HALF_W-1:0] half_val,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid,
    output logic              synced,
    output logic              idle
);
    import tsd_pkg::*;

    localparam logic [HALF_W-1:0] IDLE_PAT = {1'b0, {(HALF_W-1){1'b1}}};
    localparam logic [HALF_W-1:0] ONES_PAT = {HALF_W{1'b1}};

    tsd_state_e        state_q, state_d;
    logic [HALF_W-1:0] low_q;
    logic              is_fill;
    logic              pend_ones;

    assign is_fill   = (half_val == IDLE_PAT);
    assign pend_ones = (low_q == ONES_PAT);
    assign synced    = (state_q != ST_HUNT);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: if (found) state_d = ST_LO;
            ST_LO:   if (half_done && !is_fill) state_d = ST_HI;
            ST_HI:   if (half_done && (!is_fill || pend_ones)) state_d = ST_LO;
            default: state_d = ST_HUNT;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Output and pending-half registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q      <= '0;
            word_data  <= '0;
            word_valid <= 1'b0;
            idle       <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            unique case (state_q)
                ST_LO: begin
                    if (half_done) begin
                        if (is_fill) idle  <= 1'b1;
                        else         low_q <= half_val;
                    end
                end
                ST_HI: begin
                    if (half_done) begin
                        if (is_fill && pend_ones) begin
                            low_q <= '0;
                        end else if (is_fill) begin
                            idle <= 1'b1;
                        end else begin
                            word_data  <= {half_val, low_q};
                            word_valid <= 1'b1;
                            idle       <= 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/trace_sync_detect.sv
module trace_sync_detect #(
    parameter int MAX_PINS = 4,
    parameter int WORD_W   = 32,
    localparam int HALF_W  = WORD_W / 2,
    localparam int LANE_W  = $clog2(MAX_PINS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          width_sel,
    input  logic [MAX_PINS-1:0] pin_data,
    output logic [WORD_W-1:0]   word_data,
    output logic                word_valid,
    output logic                synced,
    output logic                idle
);

    logic [LANE_W-1:0] lane_cnt;
    logic              found;
    logic              half_done;
    logic [HALF_W-1:0] half_val;

    tsd_width_dec #(.MAX_PINS(MAX_PINS)) u_wdec (
        .width_sel (width_sel),
        .lane_cnt  (lane_cnt)
    );

    tsd_bit_shift #(.MAX_PINS(MAX_PINS), .WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_cnt  (lane_cnt),
        .pins      (pin_data),
        .found     (found),
        .half_done (half_done),
        .half_val  (half_val)
    );

    tsd_half_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .found      (found),
        .half_done  (half_done),
        .half_val   (half_val),
        .word_data  (word_data),
        .word_valid (word_valid),
        .synced     (synced),
        .idle       (idle)
    );

endmodule

// File: rtl/tsd_checker.sv
module tsd_checker #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] word_data,
    input logic              word_valid,
    input logic              synced,
    input logic              idle
);

    localparam logic [WORD_W-1:0] FULL_PAT = {1'b0, {(WORD_W-1){1'b1}}};

    // R3
    no_word_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |-> !word_valid);

    // R4
    synced_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        synced |=> synced);

    // R4
    lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(synced) |-> !word_valid);

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R6
    no_sync_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (word_data != FULL_PAT));

    // R8
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !idle);

endmodule

bind trace_sync_detect tsd_checker #(.WORD_W(WORD_W)) u_tsd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_data  (word_data),
    .word_valid (word_valid),
    .synced     (synced),
    .idle       (idle)
);

// File: tb/trace_sync_detect_bench.sv
`timescale 1ns/1ps
module trace_sync_detect_bench;

    localparam logic [31:0] FSYNC = 32'h7FFF_FFFF;
    localparam logic [15:0] HSYNC = 16'h7FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  width_sel = 2'd0;
    logic [3:0]  pin_data = 4'd0;
    logic [31:0] word_data;
    logic        word_valid;
    logic        synced;
    logic        idle;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] got[$];
    bit          bq[$];
    bit          idle_seen = 1'b0;

    always #2 clk = ~clk;

    trace_sync_detect u_trace_sync_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .width_sel  (width_sel),
        .pin_data   (pin_data),
        .word_data  (word_data),
        .word_valid (word_valid),
        .synced     (synced),
        .idle       (idle)
    );

    always @(negedge clk) begin
        if (rst_n && word_valid) got.push_back(word_data);
        if (rst_n && idle) idle_seen = 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] v, input int n);
        for (int i = 0; i < n; i++) bq.push_back(v[i]);
    endtask

    task automatic start(input logic [1:0] w);
        @(negedge clk);
        rst_n    = 1'b0;
        pin_data = 4'd0;
        width_sel = w;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        got.delete();
        bq.delete();
        idle_seen = 1'b0;
    endtask

    // Drive the queued bits; unused pins are held high; then a short drain.
    task automatic drive();
        int n;
        n = (width_sel == 2'd0) ? 1 : (width_sel == 2'd1) ? 2 : 4;
        while (bq.size() > 0) begin
            @(negedge clk);
            for (int p = 0; p < 4; p++) begin
                if (p < n) pin_data[p] = (bq.size() > 0) ? bq.pop_front() : 1'b0;
                else       pin_data[p] = 1'b1;
            end
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            for (int p = 0; p < 4; p++) pin_data[p] = (p < n) ? 1'b0 : 1'b1;
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk("R1 synced in reset", {31'd0, synced}, 32'd0);
        chk("R1 idle in reset", {31'd0, idle}, 32'd0);
        chk("R1 word_valid in reset", {31'd0, word_valid}, 32'd0);
        start(2'd0);
        @(negedge clk);
        chk("R1 synced after reset", {31'd0, synced}, 32'd0);
    endtask

    task automatic t_one_pin_hunt();
        start(2'd0);
        push(32'h5, 3);
        push(32'h0F0F_1234, 32);
        push(FSYNC, 32);
        push(32'hDEAD_BEEF, 32);
        push(32'h0000_0001, 32);
        drive();
        chk("R3 word count after offset hunt", got.size(), 32'd2);
        if (got.size() == 2) begin
            chk("R4 R2 first word one pin", got[0], 32'hDEAD_BEEF);
            chk("R5 second word one pin", got[1], 32'h0000_0001);
        end
        chk("R4 synced one pin", {31'd0, synced}, 32'd1);
    endtask

    task automatic t_two_pin_fullsync();
        start(2'd1);
        push(FSYNC, 32);
        push(32'hA5A5_0F0F, 32);
        push(FSYNC, 32);
        push(32'h1357_9BDF, 32);
        drive();
        chk("R6 words around repeated sync", got.size(), 32'd2);
        if (got.size() == 2) begin
            chk("R6 word before sync", got[0], 32'hA5A5_0F0F);
            chk("R6 R2 word after sync", got[1], 32'h1357_9BDF);
        end
        chk("R8 idle unaffected by full sync", {31'd0, idle}, 32'd0);
    endtask

    task automatic t_four_pin_idle();
        start(2'd2);
        push(32'h1, 2);
        push(FSYNC, 32);
        push(32'hCAFE_BABE, 32);
        push(HSYNC, 16);
        push(HSYNC, 16);
        push(32'h0BAD_F00D, 32);
        drive();
        chk("R7 idle halves dropped", got.size(), 32'd2);
        if (got.size() == 2) begin
            chk("R2 R3 four pin misaligned word", got[0], 32'hCAFE_BABE);
            chk("R7 word after idle", got[1], 32'h0BAD_F00D);
        end
        chk("R8 idle was raised", {31'd0, idle_seen}, 32'd1);
        chk("R8 idle cleared by word", {31'd0, idle}, 32'd0);
        start(2'd3);
        push(FSYNC, 32);
        push(32'h2468_ACE0, 32);
        push(HSYNC, 16);
        drive();
        chk("R2 code 3 uses four pins", got.size(), 32'd1);
        if (got.size() == 1) chk("R2 code 3 word", got[0], 32'h2468_ACE0);
        chk("R8 idle held after trailing fill", {31'd0, idle}, 32'd1);
    endtask

    task automatic t_idle_inside_word();
        start(2'd1);
        push(FSYNC, 32);
        push(32'h1111, 16);
        push(HSYNC, 16);
        push(32'h2222, 16);
        drive();
        chk("R7 split word count", got.size(), 32'd1);
        if (got.size() == 1) chk("R7 split word value", got[0], 32'h2222_1111);
        chk("R8 idle seen inside word", {31'd0, idle_seen}, 32'd1);
        chk("R8 idle cleared at emit", {31'd0, idle}, 32'd0);
    endtask

    task automatic t_ones_collision();
        start(2'd2);
        push(FSYNC, 32);
        push(32'hFFFF, 16);
        push(HSYNC, 16);
        push(32'hFFFF, 16);
        push(32'h1234, 16);
        drive();
        chk("R9 collision word count", got.size(), 32'd1);
        if (got.size() == 1) chk("R9 ones low half kept", got[0], 32'h1234_FFFF);
        chk("R9 R8 no idle from full sync", {31'd0, idle_seen}, 32'd0);
    endtask

    task automatic t_reset_mid();
        start(2'd1);
        push(FSYNC, 32);
        push(32'h7777_8888, 32);
        drive();
        chk("R10 word before reset", got.size(), 32'd1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R10 synced cleared by reset", {31'd0, synced}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        got.delete();
        idle_seen = 1'b0;
        push(32'h7777_8888, 32);
        push(HSYNC, 16);
        push(32'h4444_3333, 32);
        drive();
        chk("R10 no words without new sync", got.size(), 32'd0);
        chk("R10 still hunting", {31'd0, synced}, 32'd0);
        chk("R3 no idle while hunting", {31'd0, idle_seen}, 32'd0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        t_reset_state();
        t_one_pin_hunt();
        t_two_pin_fullsync();
        t_four_pin_idle();
        t_idle_inside_word();
        t_ones_collision();
        t_reset_mid();
        finish_run();
    end

endmodule